// File: doc/BRIEF.md
# Single-Digit Decimal Adder with Seven-Segment Outputs

This block adds two decimal digits, each held as a 4-bit binary-coded value, and a 1-bit carry-in. It has no clock and no storage. Every output is a continuous function of the three inputs.

The block offers the result in two forms. The first is the plain 5-bit binary total. The second is a decimal pair: a tens digit and a units digit, both 4 bits wide. It also drives four active-low seven-segment patterns, one for each operand and one for each digit of the sum. A flag reports an operand code that is not a decimal digit.

A typical use is a small display front end. An operator sets two digits and a carry and reads the result on four display positions. The binary total can also go to a row of indicator lamps. The error flag lights a warning lamp when a switch setting is out of range. The sum outputs are still produced when the flag is set, and they are not blanked.

Top module: `bcd_adder_display`

## Requirements
- R1: `bin_sum` equals `op_a + op_b + carry_in` as an unsigned 5-bit value. This holds for all 512 input combinations, including operand codes 10 to 15.
- R2: `digit_err` is 1 exactly when `op_a` or `op_b` is greater than 9. Otherwise it is 0.
- R3: When `bin_sum` is 9 or less, `sum_tens` is 0 and `sum_units` equals `bin_sum`.
- R4: When `bin_sum` is greater than 9, `sum_tens` is 1 and `sum_units` is the low four bits of `bin_sum + 6`. For valid operands this equals `bin_sum - 10`. The same rule applies when `digit_err` is set, and the outputs are not blanked.
- R5: Each segment output is 7 bits and active low, with bit 6 down to bit 0 driving segments g, f, e, d, c, b, a. The lit-segment sets for digits 0 to 9 are listed below in hex over bits g..a. The output pattern is the bitwise inverse of the listed value.
  - 0 = 3F
  - 1 = 06
  - 2 = 5B
  - 3 = 4F
  - 4 = 66
  - 5 = 6D
  - 6 = 7D
  - 7 = 07
  - 8 = 7F
  - 9 = 6F
  - Codes 10 to 15 light only segment g, giving the output pattern 0111111.
- R6: `seg_a` shows `op_a`, `seg_b` shows `op_b`, `seg_tens` shows `sum_tens` and `seg_units` shows `sum_units`. Each uses the R5 encoding.
- R7: Every output settles from a change of the inputs alone, with no clock edge involved.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 4 | First decimal operand |
| op_b | input | 4 | Second decimal operand |
| carry_in | input | 1 | Incoming carry |
| bin_sum | output | 5 | Binary total of operands and carry |
| sum_tens | output | 4 | Tens digit of the decimal total |
| sum_units | output | 4 | Units digit of the decimal total |
| digit_err | output | 1 | High when either operand exceeds 9 |
| seg_a | output | 7 | Active-low glyph for op_a |
| seg_b | output | 7 | Active-low glyph for op_b |
| seg_tens | output | 7 | Active-low glyph for the tens digit |
| seg_units | output | 7 | Active-low glyph for the units digit |

## Verification
The inputs are swept over all 512 settings of operand A, operand B and the carry.

- The sums 0 to 9 confirm the pass-through path.
- The sums 10 to 19 confirm the plus-six correction and the tens digit.
- The sums 20 to 31, which only invalid operands can reach, confirm that the correction rule still applies and that the outputs are not blanked.
- The operand codes 10 to 15 separate the error flag from the sum path. They also exercise the dash glyph on the operand displays.
- A units digit above 9 that appears under invalid operands does the same for the units display.

// File: rtl/bcd_adder_pkg.sv
package bcd_adder_pkg;
  localparam int DIGIT_W = 4;
  localparam int SUM_W   = DIGIT_W + 1;
  localparam int SEG_W   = 7;
  localparam int NUM_DISP = 4;
  localparam int GLYPH_N = 1 << DIGIT_W;
  localparam logic [DIGIT_W-1:0] MAX_DIGIT = 4'd9;
  localparam logic [DIGIT_W-1:0] DEC_ADJ   = 4'd6;

  // Lit-segment sets, bit 6 = g .. bit 0 = a, active high.
  localparam logic [SEG_W-1:0] GLYPH_ON [GLYPH_N] = '{
    7'h3F, 7'h06, 7'h5B, 7'h4F, 7'h66, 7'h6D, 7'h7D, 7'h07,
    7'h7F, 7'h6F, 7'h40, 7'h40, 7'h40, 7'h40, 7'h40, 7'h40
  };
endpackage

// File: rtl/bcd_digit_check.sv
module bcd_digit_check
  import bcd_adder_pkg::*;
(
  input  logic [DIGIT_W-1:0] digit,
  output logic               is_decimal
);
  // A code above 9 has bit 3 set together with bit 2 or bit 1.
  assign is_decimal = ~(digit[3] & (digit[2] | digit[1]));

  always_comb begin
    assert_flag_vs_value_R2: assert (is_decimal == (digit <= MAX_DIGIT))
      else $error("R2: digit check disagrees for code %0d", digit);
  end
endmodule

// File: rtl/bcd_sum_correct.sv
module bcd_sum_correct
  import bcd_adder_pkg::*;
(
  input  logic [DIGIT_W-1:0] a,
  input  logic [DIGIT_W-1:0] b,
  input  logic               cin,
  output logic [SUM_W-1:0]   total,
  output logic [DIGIT_W-1:0] tens,
  output logic [DIGIT_W-1:0] units
);
  logic over_nine;

  assign total     = {1'b0, a} + {1'b0, b} + {{DIGIT_W{1'b0}}, cin};
  assign over_nine = total[4] | (total[3] & (total[2] | total[1]));
  assign units     = total[3:0] + (over_nine ? DEC_ADJ : '0);
  assign tens      = {{(DIGIT_W-1){1'b0}}, over_nine};

  always_comb begin
    assert_units_decimal_R4: assert (!(total <= 5'd19) || units <= MAX_DIGIT)
      else $error("R4: units %0d not decimal for total %0d", units, total);
    assert_small_pass_R3: assert (!(total <= 5'd9) || (tens == '0 && units == total[3:0]))
      else $error("R3: small total %0d altered", total);
  end
endmodule

// File: rtl/seg7_glyph.sv
module seg7_glyph
  import bcd_adder_pkg::*;
(
  input  logic [DIGIT_W-1:0] digit,
  output logic [SEG_W-1:0]   seg_n
);
  assign seg_n = ~GLYPH_ON[digit];

  always_comb begin
    assert_glyph_visible_R5: assert (seg_n != {SEG_W{1'b1}})
      else $error("R5: glyph for %0d is dark", digit);
  end
endmodule

// File: rtl/bcd_adder_display.sv
module bcd_adder_display
  import bcd_adder_pkg::*;
(
  input  logic [3:0] op_a,
  input  logic [3:0] op_b,
  input  logic       carry_in,
  output logic [4:0] bin_sum,
  output logic [3:0] sum_tens,
  output logic [3:0] sum_units,
  output logic       digit_err,
  output logic [6:0] seg_a,
  output logic [6:0] seg_b,
  output logic [6:0] seg_tens,
  output logic [6:0] seg_units
);
  logic a_ok, b_ok;
  logic [DIGIT_W-1:0] disp_digit [NUM_DISP];
  logic [SEG_W-1:0]   disp_seg   [NUM_DISP];

  bcd_digit_check u_chk_a (.digit(op_a), .is_decimal(a_ok));
  bcd_digit_check u_chk_b (.digit(op_b), .is_decimal(b_ok));
  assign digit_err = ~(a_ok & b_ok);

  bcd_sum_correct u_sum (
    .a(op_a), .b(op_b), .cin(carry_in),
    .total(bin_sum), .tens(sum_tens), .units(sum_units)
  );

  assign disp_digit[0] = op_a;
  assign disp_digit[1] = op_b;
  assign disp_digit[2] = sum_tens;
  assign disp_digit[3] = sum_units;

  for (genvar gi = 0; gi < NUM_DISP; gi++) begin : g_disp
    seg7_glyph u_glyph (.digit(disp_digit[gi]), .seg_n(disp_seg[gi]));
  end

  assign seg_a     = disp_seg[0];
  assign seg_b     = disp_seg[1];
  assign seg_tens  = disp_seg[2];
  assign seg_units = disp_seg[3];

  always_comb begin
    assert_err_flag_R2: assert (digit_err == (op_a > 4'd9 || op_b > 4'd9))
      else $error("R2: error flag wrong for %0d,%0d", op_a, op_b);
    assert_decimal_value_R4: assert (digit_err || ({1'b0, sum_tens} * 5'd10 + {1'b0, sum_units}) == bin_sum)
      else $error("R4: decimal pair does not match total %0d", bin_sum);
    assert_tens_range_R6: assert (sum_tens <= 4'd1)
      else $error("R6: tens digit %0d out of range", sum_tens);
  end
endmodule

// File: tb/bcd_adder_display_tb_top.sv
module bcd_adder_display_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic [3:0] op_a = '0, op_b = '0;
  logic       carry_in = 1'b0;
  logic [4:0] bin_sum;
  logic [3:0] sum_tens, sum_units;
  logic       digit_err;
  logic [6:0] seg_a, seg_b, seg_tens, seg_units;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  bcd_adder_display dut_i (
    .op_a(op_a), .op_b(op_b), .carry_in(carry_in),
    .bin_sum(bin_sum), .sum_tens(sum_tens), .sum_units(sum_units),
    .digit_err(digit_err), .seg_a(seg_a), .seg_b(seg_b),
    .seg_tens(seg_tens), .seg_units(seg_units)
  );

  function automatic logic [6:0] glyph_n(input int d);
    logic [6:0] on;
    case (d)
      0: on = 7'h3F; 1: on = 7'h06; 2: on = 7'h5B; 3: on = 7'h4F;
      4: on = 7'h66; 5: on = 7'h6D; 6: on = 7'h7D; 7: on = 7'h07;
      8: on = 7'h7F; 9: on = 7'h6F;
      default: on = 7'h40;
    endcase
    return ~on;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s a=%0d b=%0d c=%0d actual=%0d expected=%0d",
               tag, op_a, op_b, carry_in, act, exp);
    end
  endtask

  initial begin
    #2000000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk); #1;
    // Idle state with all inputs zero
    check("R3 idle tens", sum_tens, 0);
    check("R3 idle units", sum_units, 0);
    check("R2 idle err", digit_err, 0);
    check("R5 idle seg", seg_units, 7'b1000000);
    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        for (int c = 0; c < 2; c++) begin
          @(negedge clk);
          op_a = a[3:0]; op_b = b[3:0]; carry_in = c[0];
          #1; // R7: outputs settle with no clock edge
          begin
            int s, et, eu;
            s = a + b + c;
            if (s <= 9) begin et = 0; eu = s; end
            else begin et = 1; eu = (s + 6) % 16; end
            check("R1 bin_sum", bin_sum, s);
            check("R2 digit_err", digit_err, (a > 9 || b > 9) ? 1 : 0);
            if (s <= 9) begin
              check("R3 tens", sum_tens, et);
              check("R3 units", sum_units, eu);
            end else begin
              check("R4 tens", sum_tens, et);
              check("R4 units", sum_units, eu);
            end
            check("R5 R6 seg_a", seg_a, glyph_n(a));
            check("R6 seg_b", seg_b, glyph_n(b));
            check("R6 seg_tens", seg_tens, glyph_n(et));
            check("R6 seg_units", seg_units, glyph_n(eu));
          end
        end
      end
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule